// File: doc/BRIEF.md
# Bidirectional Scan Timing Generator for a Striped Active-Matrix Panel

This block derives every scan control waveform a 1280x1024 striped active-matrix panel needs from one reference clock. A horizontal position counter and a line counter run off that clock. From them the block decodes the following outputs:

- a two-phase horizontal shift clock and its start pulse;
- a vertical shift clock and its start pulse;
- the gate enable and the precharge pulse, both inside horizontal blanking;
- a flag that marks the first step of the two-step uniformity signal;
- a line polarity flag for video inverted every line.

Each line has a video section of `H_POS` horizontal clock periods. Each period is `2*HCK_HALF` reference cycles long. The video section is followed by `H_BLANK` cycles of blanking. Inside blanking the block places, in this order: the gate enable falling edge, the precharge pulse, the uniformity step flag, the vertical clock edge, and the gate enable rising edge. Every offset and width is a parameter counted in reference cycles.

Two direction inputs select right or left scan and down or up scan. Each selection changes the polarity of the matching start pulse and its phase against the matching clock. The block samples both inputs when a frame begins. After reset it stays idle until the first frame sync pulse arrives.

Top module: `scan_timing_gen`

## Requirements
- R1: While reset is high, in the cycle after reset, and afterwards until the first frame sync, every output is low.
- R2: A frame sync pulse sampled at a clock edge restarts the block at line 0, reference position 0 from the next cycle. This holds even in the middle of a frame. The same edge samples both direction inputs and clears the line polarity flag.
- R3: While running, hck2 is always the complement of hck1. Within each line's video section, hck1 alternates every `HCK_HALF` cycles and completes `H_POS` periods. For right scan, hck1 is high in even half-periods and low throughout blanking. For left scan, hck1 is the inverse.
- R4: In right scan, hst is active high for half-periods 0 and 1 of each line and low otherwise. In left scan, hst is active low for half-periods 1 and 2 and high otherwise. The left-scan pulse is therefore shifted by half a clock period.
- R5: The vertical clock changes level once per line, at position `video + ENB_DLY + PCG_DLY + VCK_DLY`. It gives `V_LINES/2` periods per frame and is low at the start of line 0. In down scan, vck is used as is and vst is high for all of line 0. In up scan, both vck and vst are inverted.
- R6: enb falls `ENB_DLY` cycles after the video section ends and rises `ENB_LEAD` cycles before the line ends. It is high elsewhere.
- R7: pcg is high for `PCG_W` cycles, starting `PCG_DLY` cycles after enb falls. It never overlaps video or a high enb.
- R8: prg rises together with pcg and stays high for `PRG_W` cycles, where `PRG_W` is no more than `PCG_W`.
- R9: line_pol toggles at the start of every line and is cleared by frame sync.
- R10: A change on a direction input in the middle of a frame has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | One-cycle pulse that starts a frame |
| dir_right | input | 1 | 1 = right scan, 0 = left scan |
| dir_down | input | 1 | 1 = down scan, 0 = up scan |
| hst | output | 1 | Horizontal start pulse |
| hck1 | output | 1 | Horizontal clock, phase 1 |
| hck2 | output | 1 | Horizontal clock, phase 2 |
| vst | output | 1 | Vertical start pulse |
| vck | output | 1 | Vertical clock |
| enb | output | 1 | Gate enable |
| pcg | output | 1 | Precharge pulse |
| prg | output | 1 | First uniformity step flag |
| line_pol | output | 1 | Line polarity for 1H inversion |

## Verification
The hardest case to reach is a direction input that changes partway through a frame. The change must leave the waveforms untouched until the frame boundary, and then take effect exactly there.

The stimulus flips the horizontal direction in the middle of a frame and restores it before the frame ends. Later it flips the direction again and holds it across a frame boundary. The reference model samples the direction only at frame starts, so every cycle is compared against the correct latched value.

A frame sync is also placed in the middle of a frame, so the restart path is exercised away from the natural wrap.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;
  function automatic int unsigned video_cycles(int unsigned hpos, int unsigned half);
    return hpos * 2 * half;
  endfunction

  function automatic int unsigned line_cycles(int unsigned hpos, int unsigned half,
                                              int unsigned blank);
    return video_cycles(hpos, half) + blank;
  endfunction

  function automatic int unsigned pcg_start(int unsigned hpos, int unsigned half,
                                            int unsigned enb_dly, int unsigned pcg_dly);
    return video_cycles(hpos, half) + enb_dly + pcg_dly;
  endfunction

  function automatic int unsigned vck_edge(int unsigned hpos, int unsigned half,
                                           int unsigned enb_dly, int unsigned pcg_dly,
                                           int unsigned vck_dly);
    return pcg_start(hpos, half, enb_dly, pcg_dly) + vck_dly;
  endfunction
endpackage

// File: rtl/scan_hcount.sv
module scan_hcount
  import scan_timing_pkg::*;
#(
  parameter int unsigned H_POS    = 108,
  parameter int unsigned HCK_HALF = 6,
  parameter int unsigned H_BLANK  = 200,
  parameter int unsigned HW       = 12,
  parameter int unsigned FW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  output logic          run,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] half,
  output logic          video,
  output logic          line_wrap
);
  localparam int unsigned LINE = line_cycles(H_POS, HCK_HALF, H_BLANK);
  localparam int unsigned SW   = (HCK_HALF > 1) ? $clog2(HCK_HALF) : 1;
  localparam logic [HW-1:0] H_LAST   = HW'(LINE - 1);
  localparam logic [FW-1:0] HALF_END = FW'(2 * H_POS);
  localparam logic [SW-1:0] SUB_LAST = SW'(HCK_HALF - 1);

  logic [SW-1:0] sub;

  assign video     = run && (half < HALF_END);
  assign line_wrap = run && (hcnt == H_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; hcnt <= '0; half <= '0; sub <= '0;
    end else if (fsync) begin
      run <= 1'b1; hcnt <= '0; half <= '0; sub <= '0;
    end else if (run) begin
      if (line_wrap) begin
        hcnt <= '0; half <= '0; sub <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
        if (half < HALF_END) begin
          if (sub == SUB_LAST) begin
            sub  <= '0;
            half <= half + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
      end
    end
  end

  // R3: the whole video section is used up before the line wraps
  a_r3_video_done: assert property (@(posedge clk) disable iff (rst)
    line_wrap |-> (half == HALF_END));
endmodule

// File: rtl/scan_vcount.sv
module scan_vcount #(
  parameter int unsigned V_LINES = 1024,
  parameter int unsigned VW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  input  logic          line_wrap,
  input  logic          vck_turn,
  input  logic          dir_right,
  input  logic          dir_down,
  output logic [VW-1:0] vcnt,
  output logic          pol,
  output logic          vck_base,
  output logic          rr,
  output logic          dd
);
  localparam logic [VW-1:0] V_LAST = VW'(V_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt <= '0; pol <= 1'b0; vck_base <= 1'b0; rr <= 1'b0; dd <= 1'b0;
    end else if (fsync) begin
      vcnt <= '0; pol <= 1'b0; vck_base <= 1'b0;
      rr <= dir_right; dd <= dir_down;
    end else begin
      if (line_wrap) begin
        pol <= ~pol;
        if (vcnt == V_LAST) begin
          vcnt <= '0;
          rr   <= dir_right;
          dd   <= dir_down;
        end else begin
          vcnt <= vcnt + 1'b1;
        end
      end
      if (vck_turn) vck_base <= ~vck_base;
    end
  end

  a_r9_pol_flips: assert property (@(posedge clk) disable iff (rst)
    (line_wrap && !fsync) |=> (pol != $past(pol)));
  a_r5_vck_only_at_turn: assert property (@(posedge clk) disable iff (rst)
    (!vck_turn && !fsync) |=> $stable(vck_base));
  a_r10_dir_held: assert property (@(posedge clk) disable iff (rst)
    (!fsync && !(line_wrap && vcnt == V_LAST)) |=> ($stable(rr) && $stable(dd)));
endmodule

// File: rtl/scan_blank.sv
module scan_blank
  import scan_timing_pkg::*;
#(
  parameter int unsigned H_POS    = 108,
  parameter int unsigned HCK_HALF = 6,
  parameter int unsigned H_BLANK  = 200,
  parameter int unsigned ENB_DLY  = 25,
  parameter int unsigned ENB_LEAD = 20,
  parameter int unsigned PCG_DLY  = 40,
  parameter int unsigned PCG_W    = 60,
  parameter int unsigned PRG_W    = 30,
  parameter int unsigned VCK_DLY  = 10,
  parameter int unsigned HW       = 12
) (
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  output logic          enb_w,
  output logic          pcg_w,
  output logic          prg_w,
  output logic          vck_turn
);
  localparam int unsigned VID  = video_cycles(H_POS, HCK_HALF);
  localparam int unsigned LINE = line_cycles(H_POS, HCK_HALF, H_BLANK);
  localparam int unsigned P0   = pcg_start(H_POS, HCK_HALF, ENB_DLY, PCG_DLY);
  localparam int unsigned VT   = vck_edge(H_POS, HCK_HALF, ENB_DLY, PCG_DLY, VCK_DLY);
  localparam logic [HW-1:0] EF_C  = HW'(VID + ENB_DLY);
  localparam logic [HW-1:0] ER_C  = HW'(LINE - ENB_LEAD);
  localparam logic [HW-1:0] P0_C  = HW'(P0);
  localparam logic [HW-1:0] PE_C  = HW'(P0 + PCG_W);
  localparam logic [HW-1:0] RE_C  = HW'(P0 + PRG_W);
  localparam logic [HW-1:0] VT1_C = HW'(VT - 1);

  assign enb_w    = run && !((hcnt >= EF_C) && (hcnt < ER_C));
  assign pcg_w    = run && (hcnt >= P0_C) && (hcnt < PE_C);
  assign prg_w    = run && (hcnt >= P0_C) && (hcnt < RE_C);
  assign vck_turn = run && (hcnt == VT1_C);
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_timing_pkg::*;
#(
  parameter int unsigned H_POS    = 108,
  parameter int unsigned HCK_HALF = 6,
  parameter int unsigned H_BLANK  = 200,
  parameter int unsigned ENB_DLY  = 25,
  parameter int unsigned ENB_LEAD = 20,
  parameter int unsigned PCG_DLY  = 40,
  parameter int unsigned PCG_W    = 60,
  parameter int unsigned PRG_W    = 30,
  parameter int unsigned VCK_DLY  = 10,
  parameter int unsigned V_LINES  = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync,
  input  logic dir_right,
  input  logic dir_down,
  output logic hst,
  output logic hck1,
  output logic hck2,
  output logic vst,
  output logic vck,
  output logic enb,
  output logic pcg,
  output logic prg,
  output logic line_pol
);
  localparam int unsigned LINE = line_cycles(H_POS, HCK_HALF, H_BLANK);
  localparam int unsigned HW   = $clog2(LINE);
  localparam int unsigned FW   = $clog2(2 * H_POS + 1);
  localparam int unsigned VW   = $clog2(V_LINES);

  logic          run, video, line_wrap, vck_turn;
  logic [HW-1:0] hcnt;
  logic [FW-1:0] half;
  logic [VW-1:0] vcnt;
  logic          pol, vck_base, rr, dd;
  logic          enb_w, pcg_w, prg_w;
  logic          hck_base, hst_win, vst_win, hck1_i;

  scan_hcount #(.H_POS(H_POS), .HCK_HALF(HCK_HALF), .H_BLANK(H_BLANK), .HW(HW), .FW(FW)) u_h (
    .clk(clk), .rst(rst), .fsync(frame_sync), .run(run), .hcnt(hcnt),
    .half(half), .video(video), .line_wrap(line_wrap));

  scan_vcount #(.V_LINES(V_LINES), .VW(VW)) u_v (
    .clk(clk), .rst(rst), .fsync(frame_sync), .line_wrap(line_wrap),
    .vck_turn(vck_turn), .dir_right(dir_right), .dir_down(dir_down),
    .vcnt(vcnt), .pol(pol), .vck_base(vck_base), .rr(rr), .dd(dd));

  scan_blank #(.H_POS(H_POS), .HCK_HALF(HCK_HALF), .H_BLANK(H_BLANK), .ENB_DLY(ENB_DLY),
               .ENB_LEAD(ENB_LEAD), .PCG_DLY(PCG_DLY), .PCG_W(PCG_W), .PRG_W(PRG_W),
               .VCK_DLY(VCK_DLY), .HW(HW)) u_b (
    .run(run), .hcnt(hcnt), .enb_w(enb_w), .pcg_w(pcg_w), .prg_w(prg_w),
    .vck_turn(vck_turn));

  // phase decode: right scan takes half-periods 0..1, left scan 1..2
  assign hck_base = video && !half[0];
  assign hst_win  = video && (rr ? (half < FW'(2)) : ((half == FW'(1)) || (half == FW'(2))));
  assign vst_win  = (vcnt == '0);
  assign hck1_i   = rr ? hck_base : ~hck_base;

  assign hck1     = run & hck1_i;
  assign hck2     = run & ~hck1_i;
  assign hst      = run & (rr ? hst_win : ~hst_win);
  assign vst      = run & (dd ? vst_win : ~vst_win);
  assign vck      = run & (dd ? vck_base : ~vck_base);
  assign enb      = enb_w;
  assign pcg      = pcg_w;
  assign prg      = prg_w;
  assign line_pol = run & pol;

  a_r1_park: assert property (@(posedge clk)
    rst |=> ({hst, hck1, hck2, vst, vck, enb, pcg, prg, line_pol} == 9'b0));
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> (run && hcnt == '0 && vcnt == '0 && !line_pol));
  a_r3_complement: assert property (@(posedge clk) disable iff (rst)
    run |-> (hck1 != hck2));
  a_r7_pcg_in_blank: assert property (@(posedge clk) disable iff (rst)
    pcg |-> (!video && !enb));
  a_r8_prg_in_pcg: assert property (@(posedge clk) disable iff (rst)
    prg |-> pcg);
  a_r8_prg_rises_with_pcg: assert property (@(posedge clk) disable iff (rst)
    $rose(prg) |-> $rose(pcg));
endmodule

// File: tb/sim_scan_timing_gen.sv
`timescale 1ns/1ps
module sim_scan_timing_gen;
  localparam int H_POS = 4, HCK_HALF = 2, H_BLANK = 20;
  localparam int ENB_DLY = 2, ENB_LEAD = 3, PCG_DLY = 2, PCG_W = 6, PRG_W = 3, VCK_DLY = 1;
  localparam int V_LINES = 4;
  localparam int HV = H_POS * 2 * HCK_HALF;
  localparam int L = HV + H_BLANK;
  localparam int EF = HV + ENB_DLY, ER = L - ENB_LEAD;
  localparam int P0 = EF + PCG_DLY, T = P0 + VCK_DLY;
  localparam int FRAME = L * V_LINES;

  logic clk = 1'b0, rst, frame_sync, dir_right, dir_down;
  logic hst, hck1, hck2, vst, vck, enb, pcg, prg, line_pol;
  int nchk = 0, nfail = 0;

  scan_timing_gen #(.H_POS(H_POS), .HCK_HALF(HCK_HALF), .H_BLANK(H_BLANK), .ENB_DLY(ENB_DLY),
    .ENB_LEAD(ENB_LEAD), .PCG_DLY(PCG_DLY), .PCG_W(PCG_W), .PRG_W(PRG_W), .VCK_DLY(VCK_DLY),
    .V_LINES(V_LINES)) u0 (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .dir_right(dir_right), .dir_down(dir_down),
    .hst(hst), .hck1(hck1), .hck2(hck2), .vst(vst), .vck(vck), .enb(enb), .pcg(pcg),
    .prg(prg), .line_pol(line_pol));

  always #10 clk = ~clk;

  // behavioural reference state
  int mh = 0, mv = 0;
  bit mrun = 0, mpol = 0, mrr = 0, mdd = 0, synced = 0;
  bit frame_full = 0, prev_hck1 = 0, prev_vck = 0;
  int hck_moves = 0, vck_moves = 0;

  task automatic chk(input string tag, input string name, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0b expected=%0b (h=%0d v=%0d t=%0t)", tag, name, got, exp,
               mh, mv, $time);
    end
  endtask

  task automatic chk_int(input string tag, input string name, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, got, exp);
    end
  endtask

  always @(posedge clk) begin
    synced = 0;
    if (rst) begin
      mrun = 0; mh = 0; mv = 0; mpol = 0; mrr = 0; mdd = 0;
    end else if (frame_sync) begin
      mrun = 1; mh = 0; mv = 0; mpol = 0; mrr = dir_right; mdd = dir_down; synced = 1;
    end else if (mrun) begin
      if (mh == L - 1) begin
        mh = 0; mpol = !mpol;
        if (mv == V_LINES - 1) begin
          mv = 0; mrr = dir_right; mdd = dir_down;
        end else mv++;
      end else mh++;
    end
    #5;
    begin
      bit vid, base, win, vb, vw, h1;
      int half;
      string tg, th;
      vid  = mh < HV;
      half = mh / HCK_HALF;
      base = vid && (half % 2 == 0);
      win  = vid && (mrr ? (half < 2) : (half == 1 || half == 2));
      vb   = ((mv + ((mh >= T) ? 1 : 0)) % 2) == 1;
      vw   = (mv == 0);
      h1   = mrr ? base : !base;
      if (!mrun) begin
        chk("R1", "all", {hst, hck1, hck2, vst, vck, enb, pcg, prg, line_pol} == 9'b0, 1'b1);
      end else begin
        tg = synced ? "R2" : "";
        th = (mrr != dir_right) ? "R10" : "";
        chk(synced ? "R2" : (th != "" ? th : "R3"), "hck1", hck1, h1);
        chk(synced ? "R2" : (th != "" ? th : "R3"), "hck2", hck2, !h1);
        chk(synced ? "R2" : (th != "" ? th : "R4"), "hst", hst, mrr ? win : !win);
        chk(synced ? "R2" : "R5", "vck", vck, mdd ? vb : !vb);
        chk(synced ? "R2" : "R5", "vst", vst, mdd ? vw : !vw);
        chk(synced ? "R2" : "R6", "enb", enb, !(mh >= EF && mh < ER));
        chk(synced ? "R2" : "R7", "pcg", pcg, mh >= P0 && mh < P0 + PCG_W);
        chk(synced ? "R2" : "R8", "prg", prg, mh >= P0 && mh < P0 + PRG_W);
        chk(synced ? "R2" : "R9", "line_pol", line_pol, mpol);
        if (tg == "R2") begin
          hck_moves = 0; vck_moves = 0; frame_full = 1;
        end else if (mh == 0 && mv == 0) begin
          if (frame_full) begin
            chk_int("R3", "hck1 edges per frame", hck_moves, V_LINES * (2 * H_POS - 1));
            chk_int("R5", "vck edges per frame", vck_moves, V_LINES);
          end
          hck_moves = 0; vck_moves = 0; frame_full = 1;
        end else begin
          if (mh >= 1 && mh < HV && hck1 != prev_hck1) hck_moves++;
          if (vck != prev_vck) vck_moves++;
        end
      end
      if (!mrun) frame_full = 0;
      prev_hck1 = hck1;
      prev_vck  = vck;
    end
  end

  task automatic pulse_sync();
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired, run did not complete");
    finish_run();
  end

  initial begin
    rst = 1'b1; frame_sync = 1'b0; dir_right = 1'b1; dir_down = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);              // R1: idle until sync
    for (int c = 0; c < 4; c++) begin
      dir_right = (c % 2) == 0;
      dir_down  = c < 2;
      pulse_sync();                         // R2, R4, R5 for each direction pair
      repeat (FRAME + FRAME / 2) @(negedge clk);
      dir_right = !dir_right;               // R10: mid-frame flip, restored before the wrap
      repeat (20) @(negedge clk);
      dir_right = !dir_right;
      repeat (FRAME + FRAME / 2 - 21) @(negedge clk);
    end
    dir_right = 1'b0; dir_down = 1'b1;
    pulse_sync();
    repeat (FRAME / 2) @(negedge clk);
    dir_right = 1'b1;                       // R10: held across the boundary
    repeat (2 * FRAME) @(negedge clk);
    repeat (50) @(negedge clk);
    pulse_sync();                           // R2: restart mid-frame
    repeat (FRAME + 10) @(negedge clk);
    rst = 1'b1;                             // R1: reset while running
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule